// File: doc/BRIEF.md
# Reloading Event Counter Timer

This block is an up-counting timer whose count restarts from a programmable start value rather than from zero each time it rolls past its all-ones value. Each roll-over sets a sticky overflow flag. When the flag's interrupt is enabled, the flag drives an interrupt request. The counter advances on one of two sources, chosen by a select bit:

- an internal prescaled tick that is already in the system clock domain;
- an external event line, which is synchronised and edge-detected so that every rising edge advances the count exactly once.

With a start value S, the flag rises after 256 − S events. This makes the block usable both as a periodic time base and as an "interrupt after N events" detector.

A small register port gives software access to the block:

- a control/status word holding the enable, source-select and interrupt-enable bits, plus the overflow flag;
- the start (reload) value;
- a read-only view of the live count.

Reading the control/status word clears the flag. While the halt input is high, every register ignores writes and flag-clearing reads. The external-event path keeps counting during halt, and an enabled overflow during halt raises a wake request.

Top module: `evt_reload_timer`

## Requirements
- R1: After a synchronous active-low reset, the count, the reload value, the enable/select/interrupt-enable bits and the overflow flag are all 0.
- R2: Each qualified increment raises the count by exactly one while the count is below FFh.
- R3: An increment at count FFh loads the reload value into the count, not 00h.
- R4: An increment at count FFh sets the overflow flag, which then stays set until it is cleared.
- R5: `irq_o` is high exactly when the overflow flag is set and the interrupt-enable bit (control bit 2) is 1.
- R6: A read strobe at address 0 clears the overflow flag. If an overflow occurs in the same cycle, the flag stays set.
- R7: With the external source selected (control bit 1 = 1), each rising edge of `evt_i` advances the count exactly once, two clocks after the edge is sampled, however long the line stays high. With reload S, the flag rises on event 256 − S.
- R8: With the enable bit (control bit 0) at 0, the count does not change.
- R9: While `halt_i` is high, writes to the control word and to the reload value are ignored, and reads do not clear the flag.
- R10: While `halt_i` is high, external events still advance the count, but internal ticks do not.
- R11: `wake_o` is high exactly when `halt_i` is high and `irq_o` is high.
- R12: A write to the reload value (address 1) leaves the running count unchanged. The new value takes effect at the next overflow.
- R13: With the internal source selected (control bit 1 = 0), only `tick_i` advances the count and `evt_i` is ignored. With the external source selected, `tick_i` is ignored.

Register map:
- Address 0 is the control/status word: bit0 enable, bit1 external select, bit2 interrupt enable, bit7 overflow flag (read-only); all other bits read 0.
- Address 1 is the reload value.
- Address 2 is the count (read-only).
- Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Internal prescaled count tick, one clock wide per tick |
| evt_i | input | 1 | Asynchronous external event line |
| halt_i | input | 1 | Halt state: freezes registers, internal ticks stop |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (read of address 0 clears the flag) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Overflow interrupt request |
| wake_o | output | 1 | Wake request during halt |

## Verification
A wrong count or a wrong source selection shows on the count address at the next clock edge. A wrong reload value or a lost overflow shows one edge after the FFh increment, on `irq_o` and in the count. The reference model in the bench compares `irq_o`, `wake_o` and the read data on every clock, so a divergence is reported in the cycle it first reaches a port.

A miscounted external edge stays hidden only until the flag rises one event early or late. A lost flag-clear, or a clear that happens during halt, shows on the very next read of the status word.

// File: rtl/tmr_pkg.sv
// Package: shared register addresses and control bit positions for the
// reloading event counter timer. Assumes a 2-bit minimum address space.
package tmr_pkg;

    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_RELOAD = 1;
    localparam int ADDR_COUNT  = 2;

    localparam int BIT_EN  = 0;
    localparam int BIT_SEL = 1;
    localparam int BIT_IE  = 2;

    // Count source choice held in the select bit
    typedef enum logic {
        SRC_TICK  = 1'b0,
        SRC_EVENT = 1'b1
    } src_e;

endpackage

// File: rtl/evt_sync.sv
// Module: evt_sync
// Brings an asynchronous event line into the clock domain through a chain of
// STAGES flops, then emits a one-clock pulse per rising edge.
// Assumes the event line stays high and low for at least one clock each.
module evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic pulse_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Synchronizer chain: the first stage samples the raw line
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_i;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each further stage copies the one before it
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    // Edge detector memory: last synchronized level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign pulse_o = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/tmr_core.sv
// Module: tmr_core
// The count register. On each qualified increment it steps up by one; at the
// all-ones value it loads the reload value instead and flags a wrap.
// Assumes inc_i is already gated by enable, source and halt.
module tmr_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    assign wrap_o = inc_i && (cnt_q == TOP);

    // Count step or reload on roll-over
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wrap_o) cnt_q <= reload_i;
        else if (inc_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/tmr_regs.sv
// Module: tmr_regs
// Software-visible registers: control bits, reload value and the sticky
// overflow flag, plus the read-data mux. Writes and flag-clearing reads are
// blocked while halt is high. A wrap beats a clear in the same cycle.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic          wrap_i,
    input  logic [W-1:0]  cnt_i,
    output logic [W-1:0]  rdata_o,
    output logic          en_o,
    output src_e          src_o,
    output logic          ie_o,
    output logic          ovf_o,
    output logic [W-1:0]  reload_o
);

    localparam logic [AW-1:0] A_CTRL   = AW'(ADDR_CTRL);
    localparam logic [AW-1:0] A_RELOAD = AW'(ADDR_RELOAD);
    localparam logic [AW-1:0] A_COUNT  = AW'(ADDR_COUNT);

    logic   en_q, ie_q, ovf_q;
    src_e   src_q;
    logic [W-1:0] reload_q;
    logic   wr_ctrl, wr_reload, rd_clear;

    assign wr_ctrl   = wr_en_i && !halt_i && (addr_i == A_CTRL);
    assign wr_reload = wr_en_i && !halt_i && (addr_i == A_RELOAD);
    assign rd_clear  = rd_en_i && !halt_i && (addr_i == A_CTRL);

    // Control bits load from the write data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            src_q <= SRC_TICK;
            ie_q  <= 1'b0;
        end else if (wr_ctrl) begin
            en_q  <= wdata_i[BIT_EN];
            src_q <= src_e'(wdata_i[BIT_SEL]);
            ie_q  <= wdata_i[BIT_IE];
        end
    end

    // Reload value register
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= '0;
        else if (wr_reload) reload_q <= wdata_i;
    end

    // Sticky overflow flag: set wins over the read clear
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_q <= 1'b0;
        else if (wrap_i)   ovf_q <= 1'b1;
        else if (rd_clear) ovf_q <= 1'b0;
    end

    // Read data selection
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_CTRL: begin
                rdata_o[BIT_EN]  = en_q;
                rdata_o[BIT_SEL] = src_q;
                rdata_o[BIT_IE]  = ie_q;
                rdata_o[W-1]     = ovf_q;
            end
            A_RELOAD: rdata_o = reload_q;
            A_COUNT:  rdata_o = cnt_i;
            default:  rdata_o = '0;
        endcase
    end

    assign en_o     = en_q;
    assign src_o    = src_q;
    assign ie_o     = ie_q;
    assign ovf_o    = ovf_q;
    assign reload_o = reload_q;

endmodule

// File: rtl/evt_reload_timer.sv
// Module: evt_reload_timer (top)
// Reloading up-counter with internal tick or synchronized external event
// source, sticky overflow flag, interrupt and halt-time wake request.
// Assumes tick_i is synchronous and one clock wide per tick.
module evt_reload_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              evt_i,
    input  logic              halt_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              wake_o
);

    logic              evt_pulse;
    logic              cnt_inc;
    logic              wrap;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] reload_q;
    logic              ctl_en, ctl_ie, ovf_q;
    src_e              ctl_src;

    evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (evt_i),
        .pulse_o (evt_pulse)
    );

    // Increment qualifier: enable, chosen source, internal ticks stop in halt
    always_comb begin
        if (!ctl_en)                 cnt_inc = 1'b0;
        else if (ctl_src == SRC_EVENT) cnt_inc = evt_pulse;
        else                         cnt_inc = tick_i && !halt_i;
    end

    tmr_core #(.W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (cnt_inc),
        .reload_i (reload_q),
        .cnt_o    (cnt_q),
        .wrap_o   (wrap)
    );

    tmr_regs #(.W(DATA_W), .AW(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_i   (halt_i),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .wrap_i   (wrap),
        .cnt_i    (cnt_q),
        .rdata_o  (rdata_o),
        .en_o     (ctl_en),
        .src_o    (ctl_src),
        .ie_o     (ctl_ie),
        .ovf_o    (ovf_q),
        .reload_o (reload_q)
    );

    assign irq_o  = ovf_q && ctl_ie;
    assign wake_o = irq_o && halt_i;

endmodule

// File: rtl/evt_reload_timer_chk.sv
// Module: evt_reload_timer_chk
// Property checker bound into evt_reload_timer; observes ports and the
// handoff between the increment gate, the counter and the registers.
module evt_reload_timer_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halt_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              inc,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] reload,
    input logic              ovf,
    input logic              en,
    input logic              ie,
    input logic              irq_o,
    input logic              wake_o
);

    localparam logic [DATA_W-1:0] TOP = {DATA_W{1'b1}};

    // R2: single step below the top value
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt != TOP) |=> cnt == DATA_W'($past(cnt) + 1'b1));

    // R3: roll-over reloads
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt == TOP) |=> cnt == $past(reload));

    // R4: roll-over sets flag
    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt == TOP) |=> ovf);

    // R6: flag stays unless cleared by a non-halt status read
    p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(rd_en_i && !halt_i && addr_i == '0)) |=> ovf);

    // R8: disabled counter holds
    p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt));

    // R9: register contents frozen across halt
    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> ($stable(en) && $stable(ie) && $stable(reload)));

    // R12: count only moves on an increment
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt));

    // R5: interrupt only with enable
    p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ie && ovf));

    // R11: wake only in halt
    p_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (halt_i && irq_o));

endmodule

bind evt_reload_timer evt_reload_timer_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .halt_i  (halt_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .inc     (cnt_inc),
    .cnt     (cnt_q),
    .reload  (reload_q),
    .ovf     (ovf_q),
    .en      (ctl_en),
    .ie      (ctl_ie),
    .irq_o   (irq_o),
    .wake_o  (wake_o)
);

// File: tb/evt_reload_timer_test.sv
// Bench for evt_reload_timer: a behavioural reference model advanced on each
// rising edge and compared against the ports on every clock, plus directed
// checks at known points.
module evt_reload_timer_test;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       evt_i = 1'b0;
    logic       halt_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic [1:0] addr_i = 2'd0;
    logic [7:0] wdata_i = 8'd0;
    logic [7:0] rdata_o;
    logic       irq_o, wake_o;

    int n_tests = 0;
    int n_fail  = 0;

    evt_reload_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .evt_i(evt_i),
        .halt_i(halt_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    always #(PERIOD/2) clk = ~clk;

    // ---------------- reference model ----------------
    int m_cnt, m_rel, m_en, m_sel, m_ie, m_ovf;
    int h1, h2, h3;   // sampled event history, newest first

    initial begin
        m_cnt = 0; m_rel = 0; m_en = 0; m_sel = 0; m_ie = 0; m_ovf = 0;
        h1 = 0; h2 = 0; h3 = 0;
    end

    always @(posedge clk) begin
        int step, roll, nc, nrel, nen, nsel, nie, novf;
        if (!rst_n) begin
            m_cnt = 0; m_rel = 0; m_en = 0; m_sel = 0; m_ie = 0; m_ovf = 0;
            h1 = 0; h2 = 0; h3 = 0;
        end else begin
            if (m_en == 0)      step = 0;
            else if (m_sel == 1) step = (h2 == 1 && h3 == 0) ? 1 : 0;
            else                step = (tick_i && !halt_i) ? 1 : 0;
            roll = (step == 1 && m_cnt == 255) ? 1 : 0;
            nc = m_cnt; nrel = m_rel; nen = m_en; nsel = m_sel; nie = m_ie;
            novf = m_ovf;
            if (roll == 1)      nc = m_rel;
            else if (step == 1) nc = m_cnt + 1;
            if (wr_en_i && !halt_i && addr_i == 2'd0) begin
                nen = wdata_i[0]; nsel = wdata_i[1]; nie = wdata_i[2];
            end
            if (wr_en_i && !halt_i && addr_i == 2'd1) nrel = wdata_i;
            if (roll == 1) novf = 1;
            else if (rd_en_i && !halt_i && addr_i == 2'd0) novf = 0;
            m_cnt = nc; m_rel = nrel; m_en = nen; m_sel = nsel; m_ie = nie;
            m_ovf = novf;
            h3 = h2; h2 = h1; h1 = evt_i;
        end
    end

    function automatic logic [7:0] model_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {m_ovf[0], 4'b0, m_ie[0], m_sel[0], m_en[0]};
            2'd1:    return m_rel[7:0];
            2'd2:    return m_cnt[7:0];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison one time unit after each edge
    always begin
        @(posedge clk);
        #1;
        if (rst_n) begin
            check("R5 model irq_o", irq_o, (m_ovf && m_ie) ? 1 : 0);
            check("R11 model wake_o", wake_o, (m_ovf && m_ie && halt_i) ? 1 : 0);
            check("R2 model rdata", rdata_o, model_rd(addr_i));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en_i = 1'b1; addr_i = a;
        #1 v = rdata_o;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr_i = a;
        #1 v = rdata_o;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_i = 1'b1;
        repeat (n - 1) @(negedge clk);
        #0;
        @(posedge clk);
        #1 tick_i = 1'b0;
    endtask

    task automatic events(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); evt_i = 1'b1;
            repeat (3) @(negedge clk);
            evt_i = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        peek(2'd0, v); check("R1 ctrl", v, 8'h00);
        peek(2'd1, v); check("R1 reload", v, 8'h00);
        peek(2'd2, v); check("R1 count", v, 8'h00);
        check("R1 irq", irq_o, 0);

        // R12: reload write does not touch count; R2/R3/R4 via 256 ticks
        wr(2'd1, 8'hFD);
        peek(2'd2, v); check("R12 count after reload write", v, 8'h00);
        wr(2'd0, 8'h05);
        ticks(256);
        peek(2'd2, v); check("R3 count after roll", v, 8'hFD);
        peek(2'd0, v); check("R4 flag set", v, 8'h85);
        check("R5 irq with ie", irq_o, 1);

        // R6: read clear racing an overflow keeps the flag
        ticks(2);
        peek(2'd2, v); check("R2 count at top", v, 8'hFF);
        @(negedge clk);
        tick_i = 1'b1; rd_en_i = 1'b1; addr_i = 2'd0;
        @(negedge clk);
        tick_i = 1'b0; rd_en_i = 1'b0;
        peek(2'd0, v); check("R6 flag kept on race", v, 8'h85);
        rd(2'd0, v);
        peek(2'd0, v); check("R6 flag cleared by read", v, 8'h05);

        // R5: no interrupt when ie is 0
        wr(2'd0, 8'h01);
        ticks(3);
        peek(2'd0, v); check("R5 flag without ie", v, 8'h81);
        check("R5 irq masked", irq_o, 0);
        rd(2'd0, v);

        // R8: disabled counter holds
        wr(2'd0, 8'h00);
        ticks(10);
        peek(2'd2, v); check("R8 count frozen", v, 8'hFD);

        // R7/R13: external events, ticks ignored in external mode
        wr(2'd0, 8'h07);
        tick_i = 1'b1;
        events(2);
        peek(2'd2, v); check("R13 ticks ignored, two events", v, 8'hFF);
        check("R7 no irq before third event", irq_o, 0);
        events(1);
        tick_i = 1'b0;
        peek(2'd2, v); check("R7 reload after third event", v, 8'hFD);
        check("R7 irq after 256-FD events", irq_o, 1);
        rd(2'd0, v);

        // R9/R10/R11: halt with external source
        @(negedge clk); halt_i = 1'b1;
        wr(2'd1, 8'h10);
        wr(2'd0, 8'h00);
        peek(2'd1, v); check("R9 reload frozen", v, 8'hFD);
        peek(2'd0, v); check("R9 ctrl frozen", v, 8'h07);
        events(3);
        peek(2'd2, v); check("R10 events counted in halt", v, 8'hFD);
        check("R11 wake in halt", wake_o, 1);
        rd(2'd0, v);
        peek(2'd0, v); check("R9 read does not clear in halt", v, 8'h87);
        @(negedge clk); halt_i = 1'b0;
        #1 check("R11 wake drops after halt", wake_o, 0);
        rd(2'd0, v);

        // R10: internal ticks stop in halt
        wr(2'd0, 8'h05);
        @(negedge clk); halt_i = 1'b1;
        ticks(5);
        peek(2'd2, v); check("R10 ticks ignored in halt", v, 8'hFD);
        @(negedge clk); halt_i = 1'b0;

        // R13: events ignored in internal mode
        events(3);
        peek(2'd2, v); check("R13 events ignored", v, 8'hFD);

        // R12: new reload value used at the next roll-over
        wr(2'd1, 8'h80);
        peek(2'd2, v); check("R12 count unchanged", v, 8'hFD);
        ticks(3);
        peek(2'd2, v); check("R12 new reload applied", v, 8'h80);

        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule